// File: doc/BRIEF.md
# Division result consistency checker

This block takes a 32-bit numerator and denominator together with a proposed 32-bit quotient and remainder, and reports whether the proposal is a self-consistent unsigned division. It does not divide. It rebuilds quotient × denominator + remainder from 12-bit limb products. A carry runs from each partial sum into the next. The result is compared against the numerator, 16 bits at a time. A second path confirms that the remainder is strictly below the denominator. It does this with a two-stage borrow chain over 16-bit halves. This check is skipped when the denominator is zero.

One result appears per cycle. A set of operands is presented with `valid_i` high, and one clock later the block gives a combined pass flag and one failure flag for each check. Sign handling and finding the quotient belong to the surrounding logic.

Top module: `div_check`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after its release, `valid_o`, `pass_o`, `prod_err_o` and `range_err_o` are all 0.
- R2: `valid_o` equals the value `valid_i` had at the previous rising clock edge.
- R3: After a valid input, `prod_err_o` is 1 exactly when (quot × denom + rem) mod 2^32 differs from numer.
- R4: Product bits at weight 2^32 and above are discarded. For example, quot = 0x0001_0000, denom = 0x0001_0000, rem = numer gives no product error.
- R5: After a valid input with a nonzero denominator, `range_err_o` is 1 exactly when rem ≥ denom, compared as unsigned values.
- R6: The borrow from the low 16-bit half reaches the high half. rem = denom − 1 passes even when the two differ only across the half boundary, for example denom = 0x0001_0000 and rem = 0x0000_FFFF. rem = denom fails.
- R7: With denom = 0, `range_err_o` stays 0 whatever rem is, and the product check still applies (the pair passes only when rem = numer).
- R8: `pass_o` is 1 exactly when `valid_o` is 1 and neither failure flag is set.
- R9: A cycle with `valid_i` low gives all three result flags at 0 in the next cycle, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands are present this cycle |
| numer_i | input | 32 | Numerator |
| denom_i | input | 32 | Denominator |
| quot_i | input | 32 | Proposed quotient |
| rem_i | input | 32 | Proposed remainder |
| valid_o | output | 1 | Result flags belong to the previous cycle's operands |
| pass_o | output | 1 | Both checks succeeded |
| prod_err_o | output | 1 | Reconstructed product sum differs from numerator |
| range_err_o | output | 1 | Remainder not below a nonzero denominator |

## Verification
The bench aims at carry paths that cross limb boundaries. Full-scale limbs make the middle partial sum overflow its 20 bits and the top sum overflow its 8 bits. A design that kept those bits would wrongly fail wrapped products, and one that dropped a carry would fail large correct results. Remainders one below and equal to the denominator are tried at the 16-bit half boundary. A broken borrow between the halves would pass rem = denom or reject rem = denom − 1. Zero denominators are applied with rem = numer and with rem ≠ numer. This shows that the range check is gated off and the product check is not. Idle cycles with garbage operands catch flags that are not gated by the strobe.

// File: rtl/div_check_pkg.sv
package div_check_pkg;
  parameter int unsigned DATA_W  = 32;
  parameter int unsigned LIMB_W  = 12;
  parameter int unsigned N_LIMB  = 3;
  parameter int unsigned HALF_W  = DATA_W / 2;
  parameter int unsigned N_HALF  = 2;
  localparam int unsigned PROD_W = 2 * LIMB_W;
  localparam int unsigned S1_W   = DATA_W - LIMB_W;
  localparam int unsigned S2_W   = DATA_W - 2 * LIMB_W;

  typedef logic [LIMB_W-1:0] limb_t;
  typedef limb_t [N_LIMB-1:0] limbs_t;

  function automatic limbs_t split_limbs(input logic [DATA_W-1:0] v);
    limbs_t l;
    for (int i = 0; i < int'(N_LIMB); i++) begin
      l[i] = limb_t'(v >> (i * LIMB_W));
    end
    return l;
  endfunction
endpackage

// File: rtl/div_prod_chk.sv
module div_prod_chk
  import div_check_pkg::*;
(
  input  logic [DATA_W-1:0] numer_i,
  input  logic [DATA_W-1:0] denom_i,
  input  logic [DATA_W-1:0] quot_i,
  input  logic [DATA_W-1:0] rem_i,
  output logic              mismatch_o
);
  limbs_t q, d, r;
  logic [PROD_W-1:0] p [N_LIMB][N_LIMB];

  assign q = split_limbs(quot_i);
  assign d = split_limbs(denom_i);
  assign r = split_limbs(rem_i);

  for (genvar i = 0; i < N_LIMB; i++) begin : g_qi
    for (genvar j = 0; j < N_LIMB; j++) begin : g_dj
      assign p[i][j] = {{LIMB_W{1'b0}}, q[i]} * {{LIMB_W{1'b0}}, d[j]};
    end
  end

  logic [PROD_W-1:0] sum0;
  logic [S1_W-1:0]   sum1;
  logic [S2_W-1:0]   sum2;

  // weights 2^0, 2^12, 2^24; bits beyond 2^32 fall off each sum
  assign sum0 = p[0][0] + PROD_W'(r[0]);
  assign sum1 = S1_W'(p[0][1]) + S1_W'(p[1][0]) + S1_W'(r[1])
              + S1_W'(sum0[PROD_W-1:LIMB_W]);
  assign sum2 = S2_W'(p[0][2]) + S2_W'(p[1][1]) + S2_W'(p[2][0]) + S2_W'(r[2])
              + sum1[S1_W-1:LIMB_W];

  logic [HALF_W-1:0] lo_rec, hi_rec;
  assign lo_rec = {sum1[HALF_W-LIMB_W-1:0], sum0[LIMB_W-1:0]};
  assign hi_rec = {sum2, sum1[LIMB_W-1:HALF_W-LIMB_W]};

  assign mismatch_o = (lo_rec != numer_i[HALF_W-1:0]) ||
                      (hi_rec != numer_i[DATA_W-1:HALF_W]);
endmodule

// File: rtl/div_range_chk.sv
module div_range_chk
  import div_check_pkg::*;
(
  input  logic [DATA_W-1:0] denom_i,
  input  logic [DATA_W-1:0] rem_i,
  output logic              fail_o
);
  logic [N_HALF:0] carry;
  assign carry[0] = 1'b0;

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    logic [HALF_W:0] diff;
    // biased d - r - 1 + carry; top bit set means no underflow
    assign diff = {1'b1, {HALF_W{1'b0}}}
                + {1'b0, denom_i[h*HALF_W +: HALF_W]}
                - {1'b0, rem_i[h*HALF_W +: HALF_W]}
                - (HALF_W+1)'(1)
                + (HALF_W+1)'(carry[h]);
    assign carry[h+1] = diff[HALF_W];
  end

  assign fail_o = (denom_i != '0) && !carry[N_HALF];
endmodule

// File: rtl/div_check.sv
module div_check
  import div_check_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] numer_i,
  input  logic [DATA_W-1:0] denom_i,
  input  logic [DATA_W-1:0] quot_i,
  input  logic [DATA_W-1:0] rem_i,
  output logic              valid_o,
  output logic              pass_o,
  output logic              prod_err_o,
  output logic              range_err_o
);
  logic mismatch, range_fail;

  div_prod_chk u_prod (
    .numer_i   (numer_i),
    .denom_i   (denom_i),
    .quot_i    (quot_i),
    .rem_i     (rem_i),
    .mismatch_o(mismatch)
  );

  div_range_chk u_range (
    .denom_i(denom_i),
    .rem_i  (rem_i),
    .fail_o (range_fail)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      pass_o      <= 1'b0;
      prod_err_o  <= 1'b0;
      range_err_o <= 1'b0;
    end else begin
      valid_o     <= valid_i;
      pass_o      <= valid_i && !mismatch && !range_fail;
      prod_err_o  <= valid_i && mismatch;
      range_err_o <= valid_i && range_fail;
    end
  end

  a_r8_pass_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> (valid_o && !prod_err_o && !range_err_o));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!pass_o && !prod_err_o && !range_err_o));

  a_r7_zero_denom_no_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && denom_i == '0) |=> !range_err_o);

  a_r5_range_vs_compare: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && denom_i != '0) |=> (range_err_o == ($past(rem_i) >= $past(denom_i))));

  a_r3_prod_vs_arith: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (prod_err_o ==
      (DATA_W'($past(quot_i) * $past(denom_i) + $past(rem_i)) != $past(numer_i))));
endmodule

// File: tb/div_check_tb.sv
module div_check_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] numer_i = '0, denom_i = '0, quot_i = '0, rem_i = '0;
  logic        valid_o, pass_o, prod_err_o, range_err_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  div_check u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .numer_i(numer_i), .denom_i(denom_i), .quot_i(quot_i), .rem_i(rem_i),
    .valid_o(valid_o), .pass_o(pass_o), .prod_err_o(prod_err_o),
    .range_err_o(range_err_o)
  );

  task automatic check4(input string req, input logic ev, ep, epe, ere);
    n_run++;
    if ({valid_o, pass_o, prod_err_o, range_err_o} !== {ev, ep, epe, ere}) begin
      n_fail++;
      $display("FAIL %s: got v/pass/prod/range=%b%b%b%b expected %b%b%b%b",
               req, valid_o, pass_o, prod_err_o, range_err_o, ev, ep, epe, ere);
    end
  endtask

  // drive at a negedge, check at the next negedge against the model
  task automatic step(input string req, input logic v,
                      input logic [31:0] n, d, q, r);
    logic [63:0] full;
    logic ep, epe, ere;
    valid_i = v; numer_i = n; denom_i = d; quot_i = q; rem_i = r;
    full = 64'(q) * 64'(d) + 64'(r);
    epe  = v && (full[31:0] != n);
    ere  = v && (d != 0) && (r >= d);
    ep   = v && !epe && !ere;
    @(negedge clk);
    check4(req, v, ep, epe, ere);
  endtask

  task automatic good(input string req, input logic [31:0] d, q, r);
    logic [63:0] full;
    full = 64'(q) * 64'(d) + 64'(r);
    step(req, 1'b1, full[31:0], d, q, r);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check4("R1 in reset", 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check4("R1 after release", 0, 0, 0, 0);

    good("R3 simple", 32'd7, 32'd100, 32'd3);
    step("R3 corrupted numer", 1, 32'd704, 32'd7, 32'd100, 32'd3);
    good("R3 full limbs", 32'h0000_0FFF, 32'h000F_FFFF, 32'h0000_0FFE);
    good("R4 wrap 2^32", 32'h0001_0000, 32'h0001_0000, 32'h0000_0005);
    good("R4 mid-sum overflow", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000);
    step("R4 wrap wrong", 1, 32'h0000_0006, 32'h0001_0000, 32'h0001_0000, 32'h5);
    good("R6 rem=d-1 across halves", 32'h0001_0000, 32'd3, 32'h0000_FFFF);
    good("R6 rem=d", 32'h0001_0000, 32'd3, 32'h0001_0000);
    good("R5 rem>d", 32'h0000_0010, 32'd2, 32'h8000_0000);
    good("R6 rem=d-1 max", 32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFE);
    step("R7 zero denom rem=numer", 1, 32'h1234_5678, 32'd0, 32'hDEAD_BEEF, 32'h1234_5678);
    step("R7 zero denom rem!=numer", 1, 32'h1234_5678, 32'd0, 32'hDEAD_BEEF, 32'h1234_5679);
    step("R9 idle garbage", 0, 32'h1, 32'h0, 32'h5, 32'h9);
    step("R2 idle again", 0, 32'hFFFF_FFFF, 32'h3, 32'h7, 32'h9);
    step("R8 both fail", 1, 32'h0, 32'h2, 32'h1, 32'h5);

    for (int i = 0; i < 200; i++) begin
      logic [31:0] d, q, r;
      d = $urandom; q = $urandom; r = $urandom;
      if (i % 4 == 0) d = d >> (i % 31);
      if (i % 3 == 0) r = (d == 0) ? 32'd0 : r % d;
      if (i % 5 == 1) step("R3 random corrupt", 1, $urandom, d, q, r);
      else if (i % 7 == 2) step("R9 random idle", 0, $urandom, d, q, r);
      else good("R5 random", d, q, r);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule